// File: doc/BRIEF.md
# Multichannel ADC Result Sequencer

This block is the digital output stage of a converter that samples several input channels at one instant and then hands the results out one by one. A rising edge on the conversion-start input captures every channel's sample word at the same moment, together with the channel-enable mask. After a fixed latency, counted in cycles of the external conversion clock, the block produces one result per enabled channel at a steady rate. Each new result is marked by a one-cycle low pulse on the end-of-conversion output. The end-of-last-conversion flag drops together with the final pulse.

The host reads results over a 12-bit parallel bus that the block drives only while both chip-select and read are low. Each completed read strobe steps an internal read pointer to the next stored result. After the last result the pointer wraps to the first. Reads may interleave with the conversion sequence, reading each result as its pulse appears, or come after the whole sequence. Chip-select may be tied low, framed around each read strobe, or driven identically to read. All strobes are sampled on the conversion clock, so every read strobe must stay low across at least one rising edge.

Top module: `adcseq_top`

## Requirements
- R1: After reset the end-of-conversion output and the end-of-last-conversion flag are both high, and the data bus is high impedance.
- R2: A start is detected on the first rising clock edge that sees `convst` high after seeing it low. The first end-of-conversion low pulse is output from the 13th rising edge after the start edge.
- R3: Every end-of-conversion pulse is exactly one clock low. Each later pulse comes 3 clocks after the previous one, and a sequence gives exactly as many pulses as there are enabled channels.
- R4: Results are stored in slots in ascending channel-index order, and only channels whose mask bit is 1 take a slot. Each slot holds the sample word captured on the start edge; bits [12c+11:12c] of `samples` form the word of channel c.
- R5: The end-of-last-conversion flag goes low on the same edge as the final end-of-conversion pulse. It stays low until the next accepted start.
- R6: The bus carries the slot selected by the read pointer while `cs_n` and `rd_n` are both low, and is high impedance otherwise. This holds whether chip-select is held low, framed around the read, or tied to read.
- R7: The read pointer steps by one on the first rising edge after a read strobe (both strobes low) ends. It wraps from the last enabled slot back to slot 0.
- R8: An accepted start, even in the middle of a running sequence, raises the end-of-last-conversion flag, resets the read pointer to slot 0, and restarts the timing of R2.
- R9: A start edge while the enable mask is all zeros is ignored: no pulse, no change of the flag, the read pointer, or the stored results.
- R10: Changes to `samples` or `ch_en` after the start edge do not affect the results or the pulse count of the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External conversion clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| convst | input | 1 | Conversion start; a rising level starts a sequence |
| ch_en | input | 8 | Channel-enable mask, bit c enables channel c |
| samples | input | 96 | Sample words of all channels, 12 bits per channel, channel 0 in the low bits |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| dbus | output | 12 | Tri-state parallel result bus |
| eoc_n | output | 1 | End-of-conversion pulse, active low, one clock per result |
| eolc_n | output | 1 | End-of-last-conversion flag, active low |

## Verification
Counting the start edge as edge 0, slot k's end-of-conversion pulse and its stored word are due from edge 13+3k. The end-of-last-conversion flag falls at edge 13+3(n-1) for n enabled channels. The bench's reference model counts edges from each accepted start and predicts the pulse, the flag and the bus. It compares them 2 ns after every rising edge, so registered outputs have settled and the strobes, which change only on falling edges, are stable. The bus follows the strobes without a register, and the pointer moves on the first rising edge after a strobe ends. The directed checks therefore latch the bus one falling edge after lowering the strobes and measure pulse latency in whole clock counts from the start edge.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  localparam int MAX_CH = 32;

  // Number of enabled channels in a mask.
  function automatic int count_ones(input logic [MAX_CH-1:0] m);
    int n;
    n = 0;
    for (int i = 0; i < MAX_CH; i++) begin
      if (m[i]) n++;
    end
    return n;
  endfunction

  // Channel index that occupies slot n: the n-th set bit, counted from bit 0.
  function automatic int nth_enabled(input logic [MAX_CH-1:0] m, input int n);
    int seen;
    int ch;
    seen = 0;
    ch = 0;
    for (int i = 0; i < MAX_CH; i++) begin
      if (m[i]) begin
        if (seen == n) ch = i;
        seen++;
      end
    end
    return ch;
  endfunction

  // Clock edge after the start edge on which slot k becomes available.
  function automatic int slot_due(input int first_lat, input int step, input int k);
    return first_lat + step * k;
  endfunction

endpackage

// File: rtl/adcseq_timer.sv
module adcseq_timer
  import adcseq_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int FIRST_LAT = 13,
  parameter int STEP      = 3,
  parameter int SLOT_W    = 3,
  parameter int CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              convst,
  input  logic [NUM_CH-1:0] ch_en,
  output logic              req_rise,
  output logic              start_evt,
  output logic              fire_evt,
  output logic              last_evt,
  output logic [SLOT_W-1:0] slot_idx,
  output logic [CNT_W-1:0]  slot_cnt,
  output logic              eoc_n,
  output logic              eolc_n
);

  localparam int LAT_MAX = (FIRST_LAT > STEP) ? FIRST_LAT : STEP;
  localparam int GAP_W   = $clog2(LAT_MAX + 1);

  logic              convst_q;
  logic              busy;
  logic [GAP_W-1:0]  gap;
  logic [MAX_CH-1:0] en_wide;

  always_comb begin
    en_wide = '0;
    en_wide[NUM_CH-1:0] = ch_en;
  end

  assign req_rise  = convst & ~convst_q;
  assign start_evt = req_rise & (|ch_en);
  assign fire_evt  = busy & (gap == '0);
  assign last_evt  = fire_evt & (int'(slot_idx) == int'(slot_cnt) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      convst_q <= 1'b0;
      busy     <= 1'b0;
      gap      <= '0;
      slot_idx <= '0;
      slot_cnt <= '0;
      eoc_n    <= 1'b1;
      eolc_n   <= 1'b1;
    end else begin
      convst_q <= convst;
      eoc_n    <= 1'b1;
      if (start_evt) begin
        busy     <= 1'b1;
        gap      <= GAP_W'(FIRST_LAT - 1);
        slot_idx <= '0;
        slot_cnt <= CNT_W'(count_ones(en_wide));
        eolc_n   <= 1'b1;
      end else if (busy) begin
        if (fire_evt) begin
          eoc_n <= 1'b0;
          gap   <= GAP_W'(STEP - 1);
          if (last_evt) begin
            busy   <= 1'b0;
            eolc_n <= 1'b0;
          end else begin
            slot_idx <= slot_idx + 1'b1;
          end
        end else begin
          gap <= gap - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/adcseq_store.sv
module adcseq_store
  import adcseq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 12,
  parameter int SLOT_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_evt,
  input  logic [NUM_CH-1:0]       ch_en,
  input  logic [NUM_CH*RES_W-1:0] samples,
  input  logic                    fire_evt,
  input  logic [SLOT_W-1:0]       slot_idx,
  input  logic [SLOT_W-1:0]       rd_ptr,
  output logic [RES_W-1:0]        rd_word
);

  logic [RES_W-1:0]  held  [NUM_CH];
  logic [RES_W-1:0]  slots [NUM_CH];
  logic [NUM_CH-1:0] mask_q;
  logic [MAX_CH-1:0] mask_wide;
  logic [SLOT_W-1:0] src_ch;

  always_comb begin
    mask_wide = '0;
    mask_wide[NUM_CH-1:0] = mask_q;
  end

  assign src_ch = SLOT_W'(nth_enabled(mask_wide, int'(slot_idx)));

  // Simultaneous capture of every channel plus the mask on the start edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      for (int c = 0; c < NUM_CH; c++) held[c] <= '0;
    end else if (start_evt) begin
      mask_q <= ch_en;
      for (int c = 0; c < NUM_CH; c++) held[c] <= samples[c*RES_W +: RES_W];
    end
  end

  // One slot written per end-of-conversion event.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_CH; s++) slots[s] <= '0;
    end else if (fire_evt) begin
      for (int s = 0; s < NUM_CH; s++) begin
        if (slot_idx == SLOT_W'(s)) slots[s] <= held[src_ch];
      end
    end
  end

  assign rd_word = slots[rd_ptr];

endmodule

// File: rtl/adcseq_rdport.sv
module adcseq_rdport #(
  parameter int SLOT_W = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              start_evt,
  input  logic [CNT_W-1:0]  slot_cnt,
  output logic              rd_active,
  output logic              rd_end_evt,
  output logic [SLOT_W-1:0] rd_ptr
);

  logic act_q;

  assign rd_active  = ~cs_n & ~rd_n;
  assign rd_end_evt = act_q & ~rd_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      rd_ptr <= '0;
    end else begin
      act_q <= rd_active;
      if (start_evt) begin
        rd_ptr <= '0;
      end else if (rd_end_evt) begin
        if (int'(rd_ptr) + 1 >= int'(slot_cnt)) rd_ptr <= '0;
        else rd_ptr <= rd_ptr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top #(
  parameter int NUM_CH    = 8,
  parameter int RES_W     = 12,
  parameter int FIRST_LAT = 13,
  parameter int STEP      = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    convst,
  input  logic [NUM_CH-1:0]       ch_en,
  input  logic [NUM_CH*RES_W-1:0] samples,
  input  logic                    cs_n,
  input  logic                    rd_n,
  output wire  [RES_W-1:0]        dbus,
  output logic                    eoc_n,
  output logic                    eolc_n
);

  localparam int SLOT_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int CNT_W  = $clog2(NUM_CH + 1);

  logic              req_rise;
  logic              start_evt;
  logic              fire_evt;
  logic              last_evt;
  logic [SLOT_W-1:0] slot_idx;
  logic [CNT_W-1:0]  slot_cnt;
  logic [SLOT_W-1:0] rd_ptr;
  logic              rd_active;
  logic              rd_end_evt;
  logic [RES_W-1:0]  rd_word;

  adcseq_timer #(
    .NUM_CH(NUM_CH), .FIRST_LAT(FIRST_LAT), .STEP(STEP),
    .SLOT_W(SLOT_W), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .convst(convst), .ch_en(ch_en),
    .req_rise(req_rise), .start_evt(start_evt), .fire_evt(fire_evt),
    .last_evt(last_evt), .slot_idx(slot_idx), .slot_cnt(slot_cnt),
    .eoc_n(eoc_n), .eolc_n(eolc_n)
  );

  adcseq_store #(
    .NUM_CH(NUM_CH), .RES_W(RES_W), .SLOT_W(SLOT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .ch_en(ch_en),
    .samples(samples), .fire_evt(fire_evt), .slot_idx(slot_idx),
    .rd_ptr(rd_ptr), .rd_word(rd_word)
  );

  adcseq_rdport #(
    .SLOT_W(SLOT_W), .CNT_W(CNT_W)
  ) u_rdport (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n),
    .start_evt(start_evt), .slot_cnt(slot_cnt),
    .rd_active(rd_active), .rd_end_evt(rd_end_evt), .rd_ptr(rd_ptr)
  );

  assign dbus = rd_active ? rd_word : {RES_W{1'bz}};

endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
  parameter int SLOT_W = 3,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_rise,
  input logic              start_evt,
  input logic              rd_end_evt,
  input logic [SLOT_W-1:0] rd_ptr,
  input logic [CNT_W-1:0]  slot_cnt,
  input logic              eoc_n,
  input logic              eolc_n
);

  assert_eoc_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_n |=> eoc_n);

  assert_eoc_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_n |=> eoc_n ##1 eoc_n);

  assert_eolc_with_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eolc_n) |-> !eoc_n);

  assert_eolc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!eolc_n && !start_evt) |=> !eolc_n);

  assert_ptr_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_cnt != '0) |-> (int'(rd_ptr) < int'(slot_cnt)));

  assert_read_advances_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end_evt && !start_evt && int'(slot_cnt) > 1) |=> (rd_ptr != $past(rd_ptr)));

  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (eolc_n && rd_ptr == '0));

  assert_zero_mask_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rise && !start_evt) |=> $stable(slot_cnt));

endmodule

bind adcseq_top adcseq_chk #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_rise(req_rise), .start_evt(start_evt),
  .rd_end_evt(rd_end_evt), .rd_ptr(rd_ptr), .slot_cnt(slot_cnt),
  .eoc_n(eoc_n), .eolc_n(eolc_n)
);

// File: tb/sim_adcseq_top.sv
`timescale 1ns/1ps
module sim_adcseq_top;

  localparam int NCH = 8;
  localparam int RW  = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             convst = 1'b0;
  logic [NCH-1:0]   ch_en = '0;
  logic [NCH*RW-1:0] samples = '0;
  logic             cs_n = 1'b1;
  logic             rd_n = 1'b1;
  wire  [RW-1:0]    dbus;
  logic             eoc_n;
  logic             eolc_n;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int eoc_tot = 0;
  bit done = 0;

  adcseq_top u0 (
    .clk(clk), .rst_n(rst_n), .convst(convst), .ch_en(ch_en),
    .samples(samples), .cs_n(cs_n), .rd_n(rd_n), .dbus(dbus),
    .eoc_n(eoc_n), .eolc_n(eolc_n)
  );

  always #4 clk = ~clk;

  function automatic logic [RW-1:0] sval(input int ch, input int set);
    return RW'(ch * 273 + set * 1000 + 17);
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_run = 0;
  int          m_t = 0;
  int          m_n = 0;
  int          m_ptr = 0;
  bit          m_act_prev = 0;
  bit          m_cv_prev = 0;
  bit          m_eoc = 1;
  bit          m_eolc = 1;
  int          m_chans[$];
  logic [RW-1:0] m_res[$];
  logic [RW-1:0] m_hold[NCH];

  always @(posedge clk) begin
    bit act;
    int k;
    cyc++;
    act = !cs_n && !rd_n;
    if (!rst_n) begin
      m_run = 0; m_t = 0; m_n = 0; m_ptr = 0; m_eoc = 1; m_eolc = 1;
      m_chans.delete(); m_res.delete();
      act = 0;
    end else if (convst && !m_cv_prev && ch_en != '0) begin
      m_run = 1; m_t = 0; m_ptr = 0; m_eoc = 1; m_eolc = 1;
      m_chans.delete(); m_res.delete();
      for (int i = 0; i < NCH; i++) begin
        m_hold[i] = samples[i*RW +: RW];
        if (ch_en[i]) m_chans.push_back(i);
      end
      m_n = m_chans.size();
    end else begin
      m_eoc = 1;
      if (m_act_prev && !act && m_n > 0) m_ptr = (m_ptr + 1) % m_n;
      if (m_run) begin
        m_t++;
        if (m_t >= 13 && (m_t - 13) % 3 == 0) begin
          k = (m_t - 13) / 3;
          m_res.push_back(m_hold[m_chans[k]]);
          m_eoc = 0;
          if (k == m_n - 1) begin
            m_run = 0;
            m_eolc = 0;
          end
        end
      end
    end
    m_cv_prev = rst_n ? convst : 1'b0;
    m_act_prev = act;
    #2;
    if (!eoc_n) eoc_tot++;
    chk("R3 eoc_n", int'(eoc_n), int'(m_eoc));
    chk("R5 eolc_n", int'(eolc_n), int'(m_eolc));
    if (!cs_n && !rd_n) begin
      if (m_ptr < m_res.size()) chk("R4 bus value", int'(dbus), int'(m_res[m_ptr]));
    end else begin
      n_cmp++;
      if (dbus !== {RW{1'bz}}) begin
        n_bad++;
        $display("FAIL R6 bus not released: got %h expected z", dbus);
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      summary();
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic load_samples(input int set);
    for (int i = 0; i < NCH; i++) samples[i*RW +: RW] = sval(i, set);
  endtask

  task automatic start_conv(output int st);
    @(negedge clk) convst = 1'b1;
    @(negedge clk) convst = 1'b0;
    st = cyc;
  endtask

  task automatic wait_eoc;
    int lim;
    lim = 0;
    do begin
      @(negedge clk);
      lim++;
    end while (eoc_n && lim < 200);
  endtask

  // mode 0: cs held low, 1: cs framed around rd, 2: cs tied to rd
  task automatic do_read(input int mode, output logic [RW-1:0] v);
    if (mode == 1) begin
      cs_n = 1'b0;
      @(negedge clk) rd_n = 1'b0;
      @(negedge clk) v = dbus;
      rd_n = 1'b1;
      @(negedge clk) cs_n = 1'b1;
    end else begin
      cs_n = 1'b0;
      rd_n = 1'b0;
      @(negedge clk) v = dbus;
      rd_n = 1'b1;
      if (mode == 2) cs_n = 1'b1;
    end
    @(negedge clk);
  endtask

  initial begin
    int st;
    int first;
    int c0;
    logic [RW-1:0] v;

    repeat (4) @(negedge clk);
    chk("R1 eoc_n idle", int'(eoc_n), 1);
    chk("R1 eolc_n idle", int'(eolc_n), 1);
    chk("R1 bus z", int'(dbus === {RW{1'bz}}), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Channels 3 and 7, reads during the conversion.
    ch_en = 8'h88;
    load_samples(0);
    start_conv(st);
    c0 = eoc_tot;
    wait_eoc();
    chk("R2 first eoc latency", cyc - st, 13);
    first = cyc;
    ch_en = 8'hFF;          // R10: late changes must not matter
    load_samples(1);
    do_read(2, v);
    chk("R4 first slot ch3", int'(v), int'(sval(3, 0)));
    wait_eoc();
    chk("R3 eoc spacing", cyc - first, 3);
    chk("R5 eolc with last eoc", int'(eolc_n), 0);
    do_read(0, v);
    chk("R10 captured sample ch7", int'(v), int'(sval(7, 0)));
    do_read(0, v);
    chk("R7 wrap to first", int'(v), int'(sval(3, 0)));
    do_read(1, v);
    chk("R6 cs framed read", int'(v), int'(sval(7, 0)));
    do_read(2, v);
    chk("R6 cs tied to rd read", int'(v), int'(sval(3, 0)));
    chk("R3 eoc count two channels", eoc_tot - c0, 2);
    repeat (40) @(negedge clk);
    chk("R5 eolc held", int'(eolc_n), 0);
    chk("R6 bus released", int'(dbus === {RW{1'bz}}), 1);

    // Zero mask start: ignored.
    ch_en = '0;
    c0 = eoc_tot;
    start_conv(st);
    repeat (30) @(negedge clk);
    chk("R9 no eoc on zero mask", eoc_tot - c0, 0);
    chk("R9 eolc unchanged", int'(eolc_n), 0);
    do_read(0, v);
    chk("R9 pointer kept", int'(v), int'(sval(7, 0)));

    // Full mask, restarted mid-sequence.
    ch_en = 8'hFF;
    load_samples(2);
    start_conv(st);
    repeat (20) @(negedge clk);
    chk("R8 eolc raised by start", int'(eolc_n), 1);
    load_samples(3);
    start_conv(st);
    c0 = eoc_tot;
    begin
      int lim;
      lim = 0;
      while (eolc_n && lim < 200) begin
        @(negedge clk);
        lim++;
      end
    end
    chk("R5 eolc after eight slots", cyc - st, 34);
    chk("R3 eoc count eight channels", eoc_tot - c0, 8);
    for (int i = 0; i < 8; i++) begin
      do_read(i % 3, v);
      chk("R4 ascending slot", int'(v), int'(sval(i, 3)));
    end
    do_read(0, v);
    chk("R7 wrap after eight", int'(v), int'(sval(0, 3)));

    // Single channel 0.
    ch_en = 8'h01;
    load_samples(4);
    start_conv(st);
    wait_eoc();
    chk("R2 single latency", cyc - st, 13);
    chk("R5 eolc on single eoc", int'(eolc_n), 0);
    do_read(2, v);
    chk("R8 pointer reset", int'(v), int'(sval(0, 4)));
    do_read(1, v);
    chk("R7 wrap single slot", int'(v), int'(sval(0, 4)));
    repeat (5) @(negedge clk);

    done = 1;
    summary();
  end

endmodule